// File: doc/BRIEF.md
# DisplayPort Link Training Sequencer

This block is the source-side controller that brings a DisplayPort main link up. It reaches the sink's configuration registers through a byte-wide request/acknowledge port and drives the transmitter's link rate, lane count, training pattern and per-lane drive byte. After a start pulse it reads the sink's capabilities and clamps rate and lane count to the source limits. It then writes the link setup and runs clock recovery and channel equalization. During both phases it follows the sink's drive-level requests.

A run ends with `done` on success or `error` on failure. Both are held until the next start. A failed training attempt clears the training pattern and restarts the whole sequence, including the capability read, until the retry budget is used up. The physical layer, AUX signalling, pattern generation and rate fallback live elsewhere.

Top module: `dp_link_trainer`

## Requirements
- R1: After reset `busy`, `done` and `error` are 0. A start pulse while idle raises `busy`. At the end of a run exactly one of `done` (success) or `error` (failure) is set, and it is held until the next start. A start pulse while `busy` has no effect on the access sequence.
- R2: A run begins by reading sink addresses 0x001 (maximum rate), 0x002 (bits [4:0] lane count, bit 6 pattern-3 capable, bit 7 enhanced framing capable) and 0x003 (bit 0 downspread capable). The rate is then clamped to `SRC_MAX_RATE` and the lane count to `SRC_MAX_LANES`. The block reports `error` with no write and no retry in either of two cases: the rate is not 0x06, 0x0A or 0x14, or the lane count is 0.
- R3: The start phase writes the following, in this order:
  - 0x100 = rate
  - 0x101 = lane count
  - 0x107 = 0x10 only when `SSC` is set and the sink is downspread capable, else 0x00
  - 0x108 = 0x01 (8b/10b)
  - 0x102 = 0x21 (pattern 1, scrambling off)
  - 0x103+i = 0x00 for each active lane i
- R4: Status bytes are read at 0x202/0x203 (one nibble per lane: an even lane in bits [3:0], an odd lane in bits [7:4]; nibble bit 0 = clock recovered, bits [2:0] = all equalization flags), at 0x204 (bit 0 = lanes aligned) and at 0x206/0x207 (adjust nibbles, same lane layout: bits [1:0] swing, bits [3:2] pre-emphasis). The drive byte for a lane is swing in [1:0], bit 2 set when swing is 3, pre-emphasis in [4:3], and bit 5 set when pre-emphasis is 3.
- R5: Clock recovery passes when every active lane has its recovered bit set. The block then writes 0x102 = 0x03 if `SRC_MAX_RATE` is 0x14 and the sink is pattern-3 capable, else 0x02. It then writes the updated drive bytes.
- R6: While clock recovery is not done, a lane's repeat counter increments when its requested levels equal its current drive. The attempt fails when a counter reaches `CR_MAX` or when any active lane requests level 3 swing or pre-emphasis. Otherwise the new drive bytes are written and the phase repeats.
- R7: Equalization passes when lanes are aligned and every active lane shows all three equalization flags. It fails when clock recovery is lost. It also fails when an unsuccessful pass would push the loop count above `EQ_MAX`. Otherwise the updated drive bytes are written and the phase repeats.
- R8: On success the block writes 0x102 = 0x00 and then 0x101 = lane count with bit 7 set if the sink supports enhanced framing. It raises `done`, and `tx_enh` follows that same capability.
- R9: A failed attempt writes 0x102 = 0x00 and restarts from the capability read. After `RETRIES` failed attempts the block raises `error`.
- R10: Status is read `CR_WAIT` cycles after the last write in clock recovery and `EQ_WAIT` cycles after it in equalization: the first status read is granted exactly WAIT+2 cycles after the last write is granted.
- R11: A request holds its direction, address and write data stable until acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low reset |
| start | input | 1 | start pulse |
| bus_req | output | 1 | register access request |
| bus_wr | output | 1 | 1 = write, 0 = read |
| bus_addr | output | 12 | sink register address |
| bus_wdata | output | 8 | write data |
| bus_rdata | input | 8 | read data, valid with ack |
| bus_ack | input | 1 | access completed |
| tx_rate | output | 8 | link rate code to transmitter |
| tx_lanes | output | 3 | active lane count |
| tx_pattern | output | 2 | 0 none, 1/2/3 training pattern |
| tx_drive | output | 32 | per-lane drive byte, lane i at [8i+7:8i] |
| tx_enh | output | 1 | enhanced framing enabled |
| busy | output | 1 | run in progress |
| done | output | 1 | run succeeded |
| error | output | 1 | run failed |

## Verification
Every sink access is due one clock after the previous one completes. The exception is the status read: it is due exactly WAIT+2 cycles after the last write is granted. The sink model grants on falling edges and times each status read against that figure, using the clock-recovery or equalization wait according to the pattern last written. Written bytes are compared in order against a queue filled before each run. The status outputs are sampled on falling edges only after `busy` drops, so each result is read in the cycle after the final register update.

// File: rtl/dp_link_trainer.sv
module dp_link_trainer #(
  parameter logic [7:0] SRC_MAX_RATE = 8'h14,
  parameter int SRC_MAX_LANES = 4,
  parameter bit SSC = 1'b1,
  parameter int CR_MAX = 5,
  parameter int EQ_MAX = 5,
  parameter int RETRIES = 5,
  parameter int CR_WAIT = 10000,
  parameter int EQ_WAIT = 40000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  output logic        bus_req,
  output logic        bus_wr,
  output logic [11:0] bus_addr,
  output logic [7:0]  bus_wdata,
  input  logic [7:0]  bus_rdata,
  input  logic        bus_ack,
  output logic [7:0]  tx_rate,
  output logic [2:0]  tx_lanes,
  output logic [1:0]  tx_pattern,
  output logic [31:0] tx_drive,
  output logic        tx_enh,
  output logic        busy,
  output logic        done,
  output logic        error
);
  localparam int WMAX = (CR_WAIT > EQ_WAIT) ? CR_WAIT : EQ_WAIT;
  localparam int WW = $clog2(WMAX + 1);
  localparam int CW = $clog2(CR_MAX + 1);
  localparam int EW = $clog2(EQ_MAX + 2);
  localparam int TW = $clog2(RETRIES + 1);

  typedef enum logic [3:0] {S_IDLE, S_CAP, S_CHK, S_START, S_WAIT, S_STAT,
                            S_EVAL, S_PAT, S_DRV, S_FIN} st_t;
  st_t st;
  logic [3:0] idx, last;
  logic [WW-1:0] wcnt;
  logic [7:0] cap_rate, cap_lc, cap_ds, align;
  logic [15:0] stv, adj;
  logic [CW-1:0] crc [4];
  logic [CW-1:0] cnt_n [4];
  logic [EW-1:0] eqc;
  logic [TW-1:0] tries;
  logic eq_ph, pass;
  logic cr_ok, eq_ok, cr_fail;
  logic [31:0] nd;

  wire rate_ok = cap_rate == 8'h06 || cap_rate == 8'h0A || cap_rate == 8'h14;
  wire tps3 = (SRC_MAX_RATE == 8'h14) && cap_lc[6];
  wire ssc_on = SSC && cap_ds[0];

  assign bus_req = st inside {S_CAP, S_START, S_STAT, S_PAT, S_DRV, S_FIN};

  always_comb begin
    bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0; last = '0;
    case (st)
      S_CAP: begin bus_addr = 12'h001 + {8'd0, idx}; last = 4'd2; end
      S_START: begin
        bus_wr = 1'b1; last = 4'd4 + {1'b0, tx_lanes};
        case (idx)
          4'd0: begin bus_addr = 12'h100; bus_wdata = tx_rate; end
          4'd1: begin bus_addr = 12'h101; bus_wdata = {5'd0, tx_lanes}; end
          4'd2: begin bus_addr = 12'h107; bus_wdata = ssc_on ? 8'h10 : 8'h00; end
          4'd3: begin bus_addr = 12'h108; bus_wdata = 8'h01; end
          4'd4: begin bus_addr = 12'h102; bus_wdata = 8'h21; end
          default: bus_addr = 12'h0FE + {8'd0, idx};
        endcase
      end
      S_STAT: begin
        bus_addr = 12'h202 + {8'd0, idx} + ((idx >= 4'd3) ? 12'd1 : 12'd0);
        last = 4'd4;
      end
      S_PAT: begin bus_wr = 1'b1; bus_addr = 12'h102; bus_wdata = {6'd0, tx_pattern}; end
      S_DRV: begin
        bus_wr = 1'b1; bus_addr = 12'h103 + {8'd0, idx};
        bus_wdata = tx_drive[{idx[1:0], 3'b000} +: 8];
        last = {1'b0, tx_lanes} - 4'd1;
      end
      S_FIN: begin
        bus_wr = 1'b1; last = pass ? 4'd1 : 4'd0;
        if (idx == 4'd0) bus_addr = 12'h102;
        else begin bus_addr = 12'h101; bus_wdata = {tx_enh, 4'd0, tx_lanes}; end
      end
      default: ;
    endcase
  end

  always_comb begin
    cr_ok = 1'b1; eq_ok = align[0]; cr_fail = 1'b0; nd = '0;
    for (int i = 0; i < 4; i++) begin
      logic [1:0] sw, pe;
      logic hit;
      sw = adj[4*i +: 2];
      pe = adj[4*i+2 +: 2];
      nd[8*i +: 8] = {2'b00, pe == 2'd3, pe, sw == 2'd3, sw};
      hit = tx_drive[8*i +: 2] == sw && tx_drive[8*i+3 +: 2] == pe;
      cnt_n[i] = crc[i] + CW'(hit);
      if (3'(i) < tx_lanes) begin
        if (!stv[4*i]) cr_ok = 1'b0;
        if (stv[4*i +: 3] != 3'b111) eq_ok = 1'b0;
        if (32'(cnt_n[i]) == CR_MAX || sw == 2'd3 || pe == 2'd3) cr_fail = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; idx <= '0; wcnt <= '0; busy <= 1'b0; done <= 1'b0; error <= 1'b0;
      cap_rate <= '0; cap_lc <= '0; cap_ds <= '0; stv <= '0; align <= '0; adj <= '0;
      tx_rate <= '0; tx_lanes <= '0; tx_pattern <= '0; tx_drive <= '0; tx_enh <= 1'b0;
      eqc <= '0; tries <= '0; eq_ph <= 1'b0; pass <= 1'b0;
      for (int i = 0; i < 4; i++) crc[i] <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          busy <= 1'b1; done <= 1'b0; error <= 1'b0; tries <= '0; idx <= '0;
          tx_pattern <= 2'd0; tx_enh <= 1'b0; st <= S_CAP;
        end
        S_CHK: begin
          if (!rate_ok || cap_lc[4:0] == 5'd0) begin
            error <= 1'b1; busy <= 1'b0; st <= S_IDLE;
          end else begin
            tx_rate <= (cap_rate > SRC_MAX_RATE) ? SRC_MAX_RATE : cap_rate;
            tx_lanes <= (cap_lc[4:0] > 5'(SRC_MAX_LANES)) ? 3'(SRC_MAX_LANES) : cap_lc[2:0];
            tx_pattern <= 2'd1; tx_drive <= '0; eqc <= '0; eq_ph <= 1'b0; pass <= 1'b0;
            for (int i = 0; i < 4; i++) crc[i] <= '0;
            st <= S_START;
          end
        end
        S_WAIT: if (wcnt == '0) st <= S_STAT; else wcnt <= wcnt - 1'b1;
        S_EVAL: begin
          if (!eq_ph) begin
            if (cr_ok) begin
              tx_pattern <= tps3 ? 2'd3 : 2'd2; tx_drive <= nd; eq_ph <= 1'b1; st <= S_PAT;
            end else begin
              for (int i = 0; i < 4; i++) crc[i] <= cnt_n[i];
              if (cr_fail) begin tx_pattern <= 2'd0; st <= S_FIN; end
              else begin tx_drive <= nd; st <= S_DRV; end
            end
          end else if (!cr_ok) begin
            tx_pattern <= 2'd0; st <= S_FIN;
          end else begin
            tx_drive <= nd;
            if (eq_ok) begin
              pass <= 1'b1; tx_enh <= cap_lc[7]; tx_pattern <= 2'd0; st <= S_FIN;
            end else if (32'(eqc) + 1 > EQ_MAX) begin
              tx_pattern <= 2'd0; st <= S_FIN;
            end else begin
              eqc <= eqc + 1'b1; st <= S_DRV;
            end
          end
        end
        default: if (bus_req && bus_ack) begin
          if (st == S_CAP) case (idx)
            4'd0: cap_rate <= bus_rdata;
            4'd1: cap_lc <= bus_rdata;
            default: cap_ds <= bus_rdata;
          endcase
          if (st == S_STAT) case (idx)
            4'd0: stv[7:0] <= bus_rdata;
            4'd1: stv[15:8] <= bus_rdata;
            4'd2: align <= bus_rdata;
            4'd3: adj[7:0] <= bus_rdata;
            default: adj[15:8] <= bus_rdata;
          endcase
          if (idx != last) idx <= idx + 1'b1;
          else begin
            idx <= '0;
            case (st)
              S_CAP: st <= S_CHK;
              S_START: begin wcnt <= WW'(CR_WAIT); st <= S_WAIT; end
              S_STAT: st <= S_EVAL;
              S_PAT: st <= S_DRV;
              S_DRV: begin wcnt <= eq_ph ? WW'(EQ_WAIT) : WW'(CR_WAIT); st <= S_WAIT; end
              default: begin
                if (pass) begin done <= 1'b1; busy <= 1'b0; st <= S_IDLE; end
                else if (32'(tries) + 1 >= RETRIES) begin error <= 1'b1; busy <= 1'b0; st <= S_IDLE; end
                else begin tries <= tries + 1'b1; st <= S_CAP; end
              end
            endcase
          end
        end
      endcase
    end
  end

  a_r11_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_ack |=> bus_req && $stable(bus_addr) && $stable(bus_wr) && $stable(bus_wdata));
  a_r1_status_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && error) && !(busy && (done || error)));
  a_r1_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy |=> busy);
  a_r8_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> tx_pattern == 2'd0 && !bus_req);
  a_r3_pattern1_write: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_wr && bus_addr == 12'h102 && bus_wdata == 8'h21 |-> tx_pattern == 2'd1 && tx_drive == '0);
endmodule

// File: tb/dp_link_trainer_test.sv
module dp_link_trainer_test;
  localparam int CRW = 20, EQW = 40, NTRY = 5;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic bus_req, bus_wr, bus_ack = 1'b0;
  logic [11:0] bus_addr;
  logic [7:0] bus_wdata, bus_rdata = '0;
  logic [7:0] tx_rate; logic [2:0] tx_lanes; logic [1:0] tx_pattern;
  logic [31:0] tx_drive; logic tx_enh, busy, done, error;

  dp_link_trainer #(.SRC_MAX_RATE(8'h14), .SRC_MAX_LANES(2), .SSC(1'b1), .CR_MAX(5),
    .EQ_MAX(5), .RETRIES(NTRY), .CR_WAIT(CRW), .EQ_WAIT(EQW)) uut (.*);

  always #5 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0, last_wr = 0, rd_k = 0;
  bit eq_exp = 0, hung = 0;
  string tag = "R1";
  logic [19:0] q [$];
  logic [7:0] s_rate, s_lc, s_ds, s_st0, s_st1, s_adj0, s_adj1, s_align;

  task automatic chk(input bit ok, input string r, input int act, input int exp);
    checks++;
    if (!ok) begin errors++; $display("FAIL %s actual=%0h expected=%0h", r, act, exp); end
  endtask

  // sink model and scoreboard monitor
  always @(negedge clk) begin
    cyc++;
    if (bus_req && !bus_ack) begin
      bus_ack = 1'b1;
      if (bus_wr) begin
        if (q.size() == 0) chk(0, tag, {bus_addr, bus_wdata}, 0);
        else begin
          logic [19:0] e;
          e = q.pop_front();
          chk({bus_addr, bus_wdata} == e, tag, {bus_addr, bus_wdata}, e);
        end
        last_wr = cyc;
        if (bus_addr == 12'h100) begin rd_k = 0; eq_exp = 0; end
        if (bus_addr == 12'h102 && (bus_wdata == 8'h02 || bus_wdata == 8'h03)) eq_exp = 1;
      end else begin
        case (bus_addr)
          12'h001: bus_rdata = s_rate;
          12'h002: bus_rdata = s_lc;
          12'h003: bus_rdata = s_ds;
          12'h202, 12'h203: bus_rdata = (rd_k == 0) ? s_st0 : s_st1;
          12'h204: bus_rdata = s_align;
          12'h206, 12'h207: bus_rdata = (rd_k == 0) ? s_adj0 : s_adj1;
          default: bus_rdata = 8'h00;
        endcase
        if (bus_addr == 12'h202)   // R10 status read timing
          chk(cyc - last_wr == (eq_exp ? EQW : CRW) + 2, "R10", cyc - last_wr, (eq_exp ? EQW : CRW) + 2);
        if (bus_addr == 12'h207) rd_k++;
      end
    end else bus_ack = 1'b0;
  end

  initial begin
    #1500000; hung = 1;
  end

  task automatic push(input logic [11:0] a, input logic [7:0] d); q.push_back({a, d}); endtask
  task automatic push_start(input logic [7:0] r, input int ln, input logic [7:0] ds);
    push(12'h100, r); push(12'h101, 8'(ln)); push(12'h107, ds); push(12'h108, 8'h01); push(12'h102, 8'h21);
    for (int i = 0; i < ln; i++) push(12'h103 + 12'(i), 8'h00);
  endtask
  task automatic push_drv(input logic [7:0] d, input int ln);
    for (int i = 0; i < ln; i++) push(12'h103 + 12'(i), d);
  endtask
  task automatic sink(input logic [7:0] r, lc, ds, st0, st1, a0, a1, al);
    s_rate = r; s_lc = lc; s_ds = ds; s_st0 = st0; s_st1 = st1; s_adj0 = a0; s_adj1 = a1; s_align = al;
  endtask
  task automatic run(input bit exp_done, input string r, input bit poke);
    @(negedge clk); start = 1'b1; @(negedge clk); start = 1'b0;
    chk(busy == 1'b1, "R1", busy, 1);
    if (poke) begin
      repeat (15) @(negedge clk);
      start = 1'b1; @(negedge clk); start = 1'b0;  // R1: ignored while busy
    end
    while (busy && !hung) @(negedge clk);
    if (hung) chk(0, "watchdog", 0, 1);
    chk(done == exp_done && error == !exp_done, r, {done, error}, {exp_done, !exp_done});
    chk(q.size() == 0, r, q.size(), 0);
    q.delete();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && !error && !bus_req, "R1", {busy, done, error}, 0);
    rst_n = 1'b1;

    // R3 R5 R8 R2 (lane clamp 4->2), pattern 2 since sink lacks pattern-3 bit
    tag = "R3";
    sink(8'h0A, 8'h84, 8'h01, 8'h77, 8'h77, 8'h00, 8'h00, 8'h01);
    push_start(8'h0A, 2, 8'h10); push(12'h102, 8'h02); push_drv(8'h00, 2);
    push(12'h102, 8'h00); push(12'h101, 8'h82);
    run(1, "R8", 1);
    chk(tx_rate == 8'h0A && tx_lanes == 3'd2, "R2", {tx_rate, tx_lanes}, {8'h0A, 3'd2});
    chk(tx_enh && tx_pattern == 2'd0, "R8", {tx_enh, tx_pattern}, 3'b100);
    repeat (10) @(negedge clk);
    chk(done && !error, "R1", {done, error}, 2'b10);

    // R5 pattern 3, one lane, no downspread
    tag = "R5";
    sink(8'h14, 8'hC1, 8'h00, 8'h77, 8'h77, 8'h00, 8'h00, 8'h01);
    push_start(8'h14, 1, 8'h00); push(12'h102, 8'h03); push_drv(8'h00, 1);
    push(12'h102, 8'h00); push(12'h101, 8'h81);
    run(1, "R5", 0);

    // R4 adjust request swing 1 / pre-emphasis 1 -> drive 0x09
    tag = "R4";
    sink(8'h0A, 8'h04, 8'h00, 8'h00, 8'h77, 8'h55, 8'h55, 8'h01);
    push_start(8'h0A, 2, 8'h00); push_drv(8'h09, 2);
    push(12'h102, 8'h02); push_drv(8'h09, 2); push(12'h102, 8'h00); push(12'h101, 8'h02);
    run(1, "R4", 0);
    chk(tx_drive[15:0] == 16'h0909 && !tx_enh, "R4", tx_drive[15:0], 16'h0909);

    // R6 level 3 request aborts; R9 retried NTRY times
    tag = "R6";
    sink(8'h0A, 8'h02, 8'h00, 8'h00, 8'h00, 8'h33, 8'h33, 8'h00);
    for (int a = 0; a < NTRY; a++) begin push_start(8'h0A, 2, 8'h00); push(12'h102, 8'h00); end
    run(0, "R9", 0);
    chk(tx_pattern == 2'd0, "R9", tx_pattern, 0);

    // R6 repeat counter reaches CR_MAX on the fifth unchanged request
    sink(8'h0A, 8'h02, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00);
    for (int a = 0; a < NTRY; a++) begin
      push_start(8'h0A, 2, 8'h00);
      for (int k = 0; k < 4; k++) push_drv(8'h00, 2);
      push(12'h102, 8'h00);
    end
    run(0, "R6", 0);

    // R7 equalization loop limit
    tag = "R7";
    sink(8'h0A, 8'h02, 8'h00, 8'h11, 8'h11, 8'h00, 8'h00, 8'h00);
    for (int a = 0; a < NTRY; a++) begin
      push_start(8'h0A, 2, 8'h00); push(12'h102, 8'h02); push_drv(8'h00, 2);
      for (int k = 0; k < 5; k++) push_drv(8'h00, 2);
      push(12'h102, 8'h00);
    end
    run(0, "R7", 0);

    // R7 clock recovery lost during equalization
    sink(8'h0A, 8'h02, 8'h00, 8'h11, 8'h00, 8'h00, 8'h00, 8'h01);
    for (int a = 0; a < NTRY; a++) begin
      push_start(8'h0A, 2, 8'h00); push(12'h102, 8'h02); push_drv(8'h00, 2); push(12'h102, 8'h00);
    end
    run(0, "R7", 0);

    // R2 bad rate and zero lanes: error, no writes
    tag = "R2";
    sink(8'h07, 8'h02, 8'h00, 8'h77, 8'h77, 8'h00, 8'h00, 8'h01);
    run(0, "R2", 0);
    sink(8'h0A, 8'h80, 8'h00, 8'h77, 8'h77, 8'h00, 8'h00, 8'h01);
    run(0, "R2", 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule